// File: doc/BRIEF.md
# SDRAM Memory Controller

This block drives a single-rank, four-bank single-data-rate SDRAM with a 16-bit data bus. It turns one-burst read and write requests from a user port into the memory's command sequence. Every access opens a row and closes it again through auto-precharge, so no page is left open between requests. Before the first request it brings the memory up: a settling wait, a precharge of all banks, two refreshes, then programming of the mode register with the CAS latency and burst length chosen by parameter. Auto-refresh is issued on a fixed cadence derived from the 4,096-row, 64 ms retention budget.

A request is one burst of `BURST_LEN` words, handed over with a ready/valid handshake. A write carries all beats at once on `req_wdata`, with beat 0 in the low 16 bits. Read data comes back one beat per cycle with `rd_valid`. All timing gaps are parameters in picoseconds, turned into clock counts rounded up from `CLK_PS`.

Top module: `sdram_ctl`

## Requirements
- R1: After reset the controller keeps chip select high for at least INIT_PS worth of cycles. It then issues, in this order: PRECHARGE with A10 high, AUTO REFRESH, AUTO REFRESH, LOAD MODE REGISTER. `req_ready` stays low until this sequence completes.
- R2: The LOAD MODE REGISTER operand has BA = 0. A[2:0] holds the burst-length code (1→0, 2→1, 4→2, 8→3), A3 = 0 (sequential), A[6:4] holds the CAS latency (1, 2 or 3), and all other A bits are 0.
- R3: Commands are coded on (CS#, RAS#, CAS#, WE#) as ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. In every cycle with no command CS# is high, including every cycle in which `req_ready` is high.
- R4: The 23-bit word address splits into bank = addr[22:21], row = addr[20:9] and column = addr[8:0]. ACTIVE carries the row on A[11:0]. READ and WRITE carry the column on A[8:0] with A10 high for auto-precharge. No explicit PRECHARGE is issued after initialisation.
- R5: READ or WRITE follows its ACTIVE by exactly ceil(T_RCD_PS / CLK_PS) cycles.
- R6: For a READ seen by the memory at edge k, the data sampled at edges k+CAS_LAT through k+CAS_LAT+BURST_LEN−1 appear on `rd_data` with `rd_valid` one cycle later each. The beats follow sequential order, wrapping inside the BURST_LEN-aligned column block. `rd_valid` is high only for requested reads.
- R7: For a write, beat 0 is on DQ in the same cycle as the WRITE command, and the remaining beats follow on consecutive cycles. DQM is low throughout.
- R8: While read data is due, the controller leaves DQ undriven and holds DQM low.
- R9: AUTO REFRESH recurs every REF_WINDOW_NS/REF_ROWS ns, rounded down to whole cycles. It is delayed only by an access already started. A refresh falling due takes priority over a waiting request. That request is held off by `req_ready` and is served afterwards, not dropped.
- R10: After READ or WRITE, the next ACTIVE waits at least BURST_LEN + CAS_LAT + tWR + tRP cycles. After AUTO REFRESH, no command is issued for ceil(T_RC_PS / CLK_PS) cycles.
- R11: A request accepted at a clock edge (`req_valid` and `req_ready` high) puts ACTIVE with its bank and row on the pins right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W (23) | Word address {bank, row, column} |
| req_wdata | input | DQ_W*BURST_LEN (64) | Write beats, beat 0 in the low word |
| rd_data | output | DQ_W (16) | Read beat |
| rd_valid | output | 1 | `rd_data` holds a read beat |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W (2) | Bank select |
| sd_a | output | ROW_W (12) | Multiplexed row/column/operand address |
| sd_dqm | output | DQ_W/8 (2) | Byte masks, held low |
| sd_dq | inout | DQ_W (16) | Bidirectional data bus |

## Verification
The bench builds the block with CAS latency 2, burst length 4, a 20 ns clock, tRCD raised to 45 ns (three cycles), tRC of 70 ns (four cycles) and a settling time cut to 200 cycles. The refresh budget stays at its default, so a refresh is due every 781 cycles. Several refreshes therefore land in the middle of back-to-back traffic, and requests must wait behind them. A behavioural memory model in the bench also exercises bursts whose start column is not aligned, so the wrap order of the beats is covered.

// File: rtl/sdram_ctl.sv
module sdram_ctl #(
  parameter int CLK_PS        = 20000,
  parameter int T_RCD_PS      = 20000,
  parameter int T_RP_PS       = 20000,
  parameter int T_RC_PS       = 70000,
  parameter int T_WR_PS       = 15000,
  parameter int INIT_PS       = 100_000_000,
  parameter int REF_WINDOW_NS = 64_000_000,
  parameter int REF_ROWS      = 4096,
  parameter int CAS_LAT       = 2,
  parameter int BURST_LEN     = 4,
  parameter int BANK_W        = 2,
  parameter int ROW_W         = 12,
  parameter int COL_W         = 9,
  parameter int DQ_W          = 16,
  parameter int ADDR_W        = BANK_W + ROW_W + COL_W
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DQ_W*BURST_LEN-1:0] req_wdata,
  output logic [DQ_W-1:0]           rd_data,
  output logic                      rd_valid,
  output logic                      sd_cs_n,
  output logic                      sd_ras_n,
  output logic                      sd_cas_n,
  output logic                      sd_we_n,
  output logic [BANK_W-1:0]         sd_ba,
  output logic [ROW_W-1:0]          sd_a,
  output logic [DQ_W/8-1:0]         sd_dqm,
  inout  wire  [DQ_W-1:0]           sd_dq
);

  function automatic int to_cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RCD_C   = to_cyc(T_RCD_PS);
  localparam int RP_C    = to_cyc(T_RP_PS);
  localparam int RC_C    = to_cyc(T_RC_PS);
  localparam int WR_C    = to_cyc(T_WR_PS);
  localparam int INIT_C  = to_cyc(INIT_PS);
  localparam int MRD_C   = 2;
  localparam int REF_INT = REF_WINDOW_NS / REF_ROWS * 1000 / CLK_PS;
  localparam int POST_A  = BURST_LEN + CAS_LAT + WR_C + RP_C;
  localparam int POST_C  = (RC_C - RCD_C > POST_A) ? (RC_C - RCD_C) : POST_A;
  localparam int WC_W    = $clog2(INIT_C + POST_C + RC_C + 2);
  localparam int RF_W    = $clog2(REF_INT + 2);
  localparam int BL_W    = $clog2(BURST_LEN + 1);
  localparam int LIMIT   = RCD_C + POST_C + RC_C + 4;

  localparam logic [2:0] BL_CODE = (BURST_LEN == 8) ? 3'd3 :
                                   (BURST_LEN == 4) ? 3'd2 :
                                   (BURST_LEN == 2) ? 3'd1 : 3'd0;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT * 16) | ROW_W'(BL_CODE);
  localparam logic [ROW_W-1:0] AP_BIT    = ROW_W'(1 << 10);

  localparam logic [3:0] C_DESEL = 4'b1111;
  localparam logic [3:0] C_ACT   = 4'b0011;
  localparam logic [3:0] C_RD    = 4'b0101;
  localparam logic [3:0] C_WR    = 4'b0100;
  localparam logic [3:0] C_PRE   = 4'b0010;
  localparam logic [3:0] C_REF   = 4'b0001;
  localparam logic [3:0] C_LMR   = 4'b0000;

  typedef enum logic [2:0] {S_PWR, S_IREF1, S_IREF2, S_ILMR, S_IDLE, S_ACC} st_t;

  st_t                      st;
  logic [WC_W-1:0]          wcnt;
  logic [RF_W-1:0]          ref_cnt;
  logic                     ref_due;
  logic [3:0]               cmd;
  logic [BANK_W-1:0]        r_bank;
  logic [COL_W-1:0]         r_col;
  logic                     r_write;
  logic [DQ_W*BURST_LEN-1:0] wbuf;
  logic                     dq_oe;
  logic [DQ_W-1:0]          dq_out;
  logic [BL_W-1:0]          wleft, rleft;
  logic [CAS_LAT-1:0]       rp;
  logic                     rd_go;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_dqm    = '0;
  assign sd_dq     = dq_oe ? dq_out : {DQ_W{1'bz}};
  assign rd_go     = (rleft != '0);
  assign req_ready = (st == S_IDLE) && (wcnt == '0) && !ref_due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_PWR;
      wcnt    <= WC_W'(INIT_C);
      cmd     <= C_DESEL;
      sd_ba   <= '0;
      sd_a    <= '0;
      r_bank  <= '0;
      r_col   <= '0;
      r_write <= 1'b0;
      wbuf    <= '0;
      dq_oe   <= 1'b0;
      dq_out  <= '0;
      wleft   <= '0;
      rleft   <= '0;
      rp      <= '0;
      ref_cnt <= '0;
      ref_due <= 1'b0;
    end else begin
      cmd <= C_DESEL;
      rp  <= CAS_LAT'({rp, rd_go});
      if (rd_go) rleft <= rleft - 1'b1;
      if (wleft != '0) begin
        dq_out <= wbuf[DQ_W-1:0];
        wbuf   <= wbuf >> DQ_W;
        wleft  <= wleft - 1'b1;
      end else begin
        dq_oe <= 1'b0;
      end

      if (wcnt != '0) begin
        wcnt <= wcnt - 1'b1;
      end else begin
        case (st)
          S_PWR: begin
            cmd  <= C_PRE;
            sd_a <= AP_BIT;
            wcnt <= WC_W'(RP_C - 1);
            st   <= S_IREF1;
          end
          S_IREF1: begin
            cmd  <= C_REF;
            wcnt <= WC_W'(RC_C - 1);
            st   <= S_IREF2;
          end
          S_IREF2: begin
            cmd  <= C_REF;
            wcnt <= WC_W'(RC_C - 1);
            st   <= S_ILMR;
          end
          S_ILMR: begin
            cmd   <= C_LMR;
            sd_ba <= '0;
            sd_a  <= MODE_WORD;
            wcnt  <= WC_W'(MRD_C - 1);
            st    <= S_IDLE;
          end
          S_IDLE: begin
            if (ref_due) begin
              cmd     <= C_REF;
              ref_due <= 1'b0;
              wcnt    <= WC_W'(RC_C - 1);
            end else if (req_valid) begin
              cmd     <= C_ACT;
              sd_ba   <= req_addr[ADDR_W-1 -: BANK_W];
              sd_a    <= req_addr[COL_W +: ROW_W];
              r_bank  <= req_addr[ADDR_W-1 -: BANK_W];
              r_col   <= req_addr[COL_W-1:0];
              r_write <= req_write;
              wbuf    <= req_wdata;
              wcnt    <= WC_W'(RCD_C - 1);
              st      <= S_ACC;
            end
          end
          S_ACC: begin
            cmd   <= r_write ? C_WR : C_RD;
            sd_ba <= r_bank;
            sd_a  <= ROW_W'(r_col) | AP_BIT;
            wcnt  <= WC_W'(POST_C - 1);
            st    <= S_IDLE;
            if (r_write) begin
              dq_oe  <= 1'b1;
              dq_out <= wbuf[DQ_W-1:0];
              wbuf   <= wbuf >> DQ_W;
              wleft  <= BL_W'(BURST_LEN - 1);
            end else begin
              rleft  <= BL_W'(BURST_LEN);
            end
          end
          default: st <= S_PWR;
        endcase
      end

      if (ref_cnt == RF_W'(REF_INT - 1)) begin
        ref_cnt <= '0;
        ref_due <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rp[CAS_LAT-1];
      rd_data  <= sd_dq;
    end
  end

  logic [15:0] since_act, since_ref, due_age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '1;
      since_ref <= '1;
      due_age   <= '0;
    end else begin
      if (cmd == C_ACT) since_act <= 16'd1;
      else if (since_act != '1) since_act <= since_act + 16'd1;
      if (cmd == C_REF) since_ref <= 16'd1;
      else if (since_ref != '1) since_ref <= since_ref + 16'd1;
      if (!ref_due) due_age <= '0;
      else if ((st == S_IDLE || st == S_ACC) && due_age != '1) due_age <= due_age + 16'd1;
    end
  end

  a_r5_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |-> since_act == 16'(RCD_C));

  a_r10_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since_ref < 16'(RC_C)) |-> (cmd == C_DESEL));

  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rp != '0) |-> !dq_oe);

  a_r9_ref_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    due_age < 16'(LIMIT));

  a_r11_accept_act: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == C_ACT
      && sd_a == $past(req_addr[COL_W +: ROW_W])
      && sd_ba == $past(req_addr[ADDR_W-1 -: BANK_W])));

endmodule

// File: tb/sim_sdram_ctl.sv
module sim_sdram_ctl;
  localparam int BL = 4;
  localparam int CL = 2;
  localparam int E_RCD  = 3;
  localparam int E_RC   = 4;
  localparam int E_INIT = 200;
  localparam int E_REF  = 781;
  localparam int E_POST = BL + CL + 1;
  localparam logic [11:0] E_MODE = 12'h022;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, req_valid, req_write;
  logic [22:0] req_addr;
  logic [63:0] req_wdata;
  wire         req_ready, rd_valid;
  wire  [15:0] rd_data;
  wire         cs_n, ras_n, cas_n, we_n;
  wire  [1:0]  ba, dqm;
  wire  [11:0] a;
  wire  [15:0] dq;
  logic        m_oe;
  logic [15:0] m_dq;
  assign dq = m_oe ? m_dq : 16'hzzzz;

  sdram_ctl #(.CLK_PS(20000), .T_RCD_PS(45000), .T_RP_PS(20000), .T_RC_PS(70000),
              .T_WR_PS(15000), .INIT_PS(4_000_000), .CAS_LAT(CL), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_a(a), .sd_dqm(dqm), .sd_dq(dq));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] beat_addr(input logic [22:0] b, input int i);
    logic [22:0] m;
    m = 23'(BL - 1);
    return (b & ~m) | ((b + 23'(i)) & m);
  endfunction

  function automatic logic [15:0] dflt(input logic [22:0] ad);
    return ad[15:0] ^ 16'h5A5A;
  endfunction

  logic [15:0] mem    [logic [22:0]];
  logic [15:0] shadow [logic [22:0]];
  logic [15:0] exp_q  [$];
  logic [11:0] open_row [4];

  int cyc, ncmd, nref, last_act, last_rw, last_ref;
  int wr_left, wr_idx, rd_left, rd_idx, rd_dly;
  logic [22:0] wr_base, rd_base, base;
  logic [2:0]  c;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; ncmd = 0; nref = 0; last_act = -100; last_rw = -100; last_ref = -100;
      wr_left = 0; rd_left = 0;
      m_oe <= 1'b0;
      m_dq <= '0;
    end else begin
      cyc++;
      if (wr_left > 0) begin
        mem[beat_addr(wr_base, wr_idx)] = dq;
        wr_idx++;
        wr_left--;
      end
      if (!cs_n) begin
        c = {ras_n, cas_n, we_n};
        if (ncmd == 0) begin
          chk(c == 3'b010 && a[10], "R1 first command precharge-all", {c, a}, {3'b010, 12'h400});
          chk(cyc >= E_INIT, "R1 settling time", cyc, E_INIT);
        end else if (ncmd == 1 || ncmd == 2) begin
          chk(c == 3'b001, "R1 init refresh", c, 3'b001);
        end else if (ncmd == 3) begin
          chk(c == 3'b000, "R1 init load mode", c, 3'b000);
        end
        case (c)
          3'b011: begin
            chk(cyc - last_rw >= E_POST, "R10 access to activate gap", cyc - last_rw, E_POST);
            chk(cyc - last_ref >= E_RC, "R10 refresh to activate gap", cyc - last_ref, E_RC);
            open_row[ba] = a;
            last_act = cyc;
          end
          3'b101, 3'b100: begin
            chk(cyc - last_act == E_RCD, "R5 activate to access gap", cyc - last_act, E_RCD);
            chk(a[10] == 1'b1, "R4 auto-precharge bit", a[10], 1);
            base = {ba, open_row[ba], a[8:0]};
            last_rw = cyc;
            if (c == 3'b100) begin
              chk(dqm == 2'b00, "R7 mask low on write", dqm, 0);
              mem[base] = dq;
              wr_base = base; wr_idx = 1; wr_left = BL - 1;
            end else begin
              rd_base = base; rd_idx = 0; rd_left = BL; rd_dly = CL - 1;
            end
          end
          3'b001: begin
            if (ncmd >= 4) begin
              chk(cyc - last_ref <= E_REF + 16, "R9 refresh interval", cyc - last_ref, E_REF);
              chk(cyc - last_rw >= E_POST, "R10 access to refresh gap", cyc - last_rw, E_POST);
            end
            last_ref = cyc;
            nref++;
          end
          3'b010: if (ncmd >= 4) chk(1'b0, "R4 explicit precharge after init", c, 3'b011);
          3'b000: chk(a == E_MODE && ba == 2'b00, "R2 mode operand", {ba, a}, E_MODE);
          default: chk(1'b0, "R3 illegal command code", c, 0);
        endcase
        ncmd++;
      end
      if (rd_left > 0) begin
        if (rd_dly == 0) begin
          base = beat_addr(rd_base, rd_idx);
          m_dq <= mem.exists(base) ? mem[base] : dflt(base);
          m_oe <= 1'b1;
          chk(dqm == 2'b00, "R8 mask low on read", dqm, 0);
          rd_idx++;
          rd_left--;
        end else begin
          rd_dly--;
        end
      end else begin
        m_oe <= 1'b0;
      end
    end
  end

  logic [15:0] e;
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_ready) chk(cs_n == 1'b1, "R3 deselect while idle", cs_n, 1);
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected rd_valid", rd_data, 0);
        else begin
          e = exp_q.pop_front();
          chk(rd_data == e, "R6 read beat", rd_data, e);
        end
      end
    end
  end

  task automatic send(input bit wr, input logic [22:0] ad, input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    for (int i = 0; i < BL; i++) begin
      if (wr) shadow[beat_addr(ad, i)] = wd[16*i +: 16];
      else exp_q.push_back(shadow.exists(beat_addr(ad, i)) ? shadow[beat_addr(ad, i)]
                                                             : dflt(beat_addr(ad, i)));
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0011 && a == ad[20:9] && ba == ad[22:21],
        "R11 activate follows accept", {cs_n, ras_n, cas_n, we_n, ba, a}, {4'b0011, ad[22:9]});
  endtask

  logic [31:0] lf;
  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R3 deselect in reset", cs_n, 1);
    chk(req_ready == 1'b0, "R1 not ready in reset", req_ready, 0);
    chk(rd_valid == 1'b0, "R6 no read valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk(req_ready == 1'b0, "R1 not ready during init", req_ready, 0);

    send(1'b1, 23'h000000, 64'h1111_2222_3333_4444);
    send(1'b0, 23'h000000, '0);
    send(1'b1, 23'h7FFFFC, 64'hFEDC_BA98_7654_3210);
    send(1'b0, 23'h7FFFFC, '0);
    send(1'b1, {2'd1, 12'd5, 9'd8}, 64'hA5A5_0F0F_F0F0_5A5A);
    send(1'b1, {2'd1, 12'd6, 9'd8}, 64'h0001_0002_0003_0004);
    send(1'b0, {2'd1, 12'd5, 9'd8}, '0);
    send(1'b0, {2'd1, 12'd6, 9'd8}, '0);
    send(1'b0, {2'd1, 12'd5, 9'd10}, '0);
    send(1'b1, {2'd2, 12'd7, 9'd1}, 64'hCAFE_BEEF_D00D_F00D);
    send(1'b0, {2'd2, 12'd7, 9'd0}, '0);
    send(1'b0, {2'd3, 12'd4095, 9'd100}, '0);

    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 160; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      send(lf[8], {lf[1:0], 9'd0, lf[4:2], lf[7:5], 6'd0}, {lf, ~lf});
    end

    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
    repeat (1700) @(negedge clk);
    chk(nref >= 5, "R9 refreshes seen", nref, 5);
    chk(ncmd >= 4, "R1 init completed", ncmd, 4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule